// File: doc/BRIEF.md
# Serial Interrupt Priority Identification Unit

This block gathers the interrupt conditions of an infrared-capable serial port and presents the most urgent one through a read-only identification byte. It also drives a single interrupt request line. The sources are receive line errors, receive data availability (or the receive FIFO reaching its trigger level), a receive idle time-out and transmit buffer empty. Each source has its own enable bit, applied before the priority choice.

The block does not hold any serial data. Sticky sources are cleared through strobes that the bus side raises on a line-status read, a receive-buffer read, an identification read or a transmit-buffer write. Level sources follow their status inputs. The receive idle time-out comes from a counter of character-time ticks. It runs only while FIFO mode is on and the receive FIFO holds data, and it restarts on every push into or read from that FIFO.

Top module: `sirq_id_unit`

## Requirements
- R1: After reset, with FIFO mode off, the identification byte reads 8'h01 and `irq` is 0.
- R2: Bits 7 and 6 of the identification byte both equal `fifo_en`, and bits 5 and 4 always read 0.
- R3: Bit 0 reads 1 exactly when no enabled source is pending, and `irq` is always the inverse of bit 0.
- R4: A pulse on any bit of `rx_err` (overrun, parity, missing stop bit, break) sets a pending receive error. From the next cycle it reads as code 4'b0110 in bits 3:0. It stays until a cycle with `lsr_rd` high, and is gone in the cycle after that.
- R5: Receive data reads as code 4'b0100 in the same cycle as its level. The level is `rx_ready` when FIFO mode is off and `rx_trig` when it is on. The code clears when that level falls, and the unselected input is ignored.
- R6: In FIFO mode, with `rx_nonempty` high, reaching `TIMEOUT_CHARS` `char_tick` pulses reads as code 4'b1100 from the cycle after the last tick. A cycle with `rx_push`, `rbr_rd` or an empty FIFO restarts the count, and `rbr_rd` clears a reported time-out.
- R7: With FIFO mode off, bit 3 is never 1 and the time-out code is never reported, whatever ticks arrive.
- R8: A 0-to-1 change of `tx_empty` sets a pending transmit-empty, read as code 4'b0010 from the next cycle. A cycle with `thr_wr` high clears it.
- R9: A cycle with `iir_rd` high clears the pending transmit-empty only if code 4'b0010 is the code being reported in that cycle. Otherwise the read leaves it pending.
- R10: Priority is receive error first, then receive data, then time-out, then transmit-empty.
- R11: A source whose enable is 0 does not change the identification byte. A sticky source latched while disabled appears once its enable is set.
- R12: When a set event and its clear strobe arrive in the same cycle, the source stays pending. This holds for the receive error with `lsr_rd`, and for the transmit-empty with `iir_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO mode enable |
| en_rxerr | input | 1 | Enable for receive error source |
| en_rxdata | input | 1 | Enable for receive data and time-out sources |
| en_txempty | input | 1 | Enable for transmit-empty source |
| rx_err | input | ERR_W | Single-cycle receive error event flags |
| rx_ready | input | 1 | Receive holding register full (non-FIFO mode) |
| rx_trig | input | 1 | Receive FIFO at or above trigger level |
| rx_nonempty | input | 1 | Receive FIFO holds at least one character |
| rx_push | input | 1 | A character was pushed into the receive FIFO |
| char_tick | input | 1 | Single-cycle pulse once per character time |
| tx_empty | input | 1 | Transmit buffer empty level |
| lsr_rd | input | 1 | Line status register read strobe |
| rbr_rd | input | 1 | Receive buffer read strobe |
| thr_wr | input | 1 | Transmit buffer write strobe |
| iir_rd | input | 1 | Identification register read strobe |
| iir_data | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench uses `TIMEOUT_CHARS` = 4 and `ERR_W` = 4. The short time-out lets it reach the exact tick at which the time-out appears, a restart by a push one tick before expiry, and a clear by emptying the FIFO, each within a few cycles. All four error bits are small enough to pulse one by one. A behavioural model compares the byte and the request line on every clock. Directed steps cover the priority ties, the enable masking and the same-cycle set/clear collisions.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    typedef enum logic [3:0] {
        IID_NONE    = 4'b0001,
        IID_RXERR   = 4'b0110,
        IID_RXDATA  = 4'b0100,
        IID_RXIDLE  = 4'b1100,
        IID_TXEMPTY = 4'b0010
    } iid_e;

    typedef struct packed {
        logic rxerr;
        logic rxdata;
        logic rxidle;
        logic txempty;
    } src_t;

    // Highest-urgency source wins.
    function automatic iid_e pick_code(src_t s);
        iid_e c;
        if (s.rxerr)        c = IID_RXERR;
        else if (s.rxdata)  c = IID_RXDATA;
        else if (s.rxidle)  c = IID_RXIDLE;
        else if (s.txempty) c = IID_TXEMPTY;
        else                c = IID_NONE;
        return c;
    endfunction

    function automatic logic [7:0] pack_iir(logic fifo_on, iid_e c);
        return {fifo_on, fifo_on, 2'b00, c};
    endfunction

endpackage

// File: rtl/sirq_sticky.sv
module sirq_sticky #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    // Set has precedence over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst)        pend_o <= RST_VAL;
        else if (set_i) pend_o <= 1'b1;
        else if (clr_i) pend_o <= 1'b0;
    end
endmodule

// File: rtl/sirq_idle_timer.sv
module sirq_idle_timer #(
    parameter int CHARS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic restart_i,
    input  logic tick_i,
    output logic expired_o
);
    localparam int CW = $clog2(CHARS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(CHARS);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i || restart_i) cnt_q <= '0;
        else if (tick_i && cnt_q != LIMIT) cnt_q <= cnt_q + CW'(1);
    end

    assign expired_o = (cnt_q == LIMIT);
endmodule

// File: rtl/sirq_prio_enc.sv
module sirq_prio_enc
    import sirq_pkg::*;
(
    input  src_t        req_i,
    input  logic        fifo_on_i,
    output iid_e        code_o,
    output logic [7:0]  iir_o
);
    always_comb begin
        code_o = pick_code(req_i);
        iir_o  = pack_iir(fifo_on_i, code_o);
    end
endmodule

// File: rtl/sirq_id_unit.sv
module sirq_id_unit
    import sirq_pkg::*;
#(
    parameter int TIMEOUT_CHARS = 4,
    parameter int ERR_W         = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_en,
    input  logic             en_rxerr,
    input  logic             en_rxdata,
    input  logic             en_txempty,
    input  logic [ERR_W-1:0] rx_err,
    input  logic             rx_ready,
    input  logic             rx_trig,
    input  logic             rx_nonempty,
    input  logic             rx_push,
    input  logic             char_tick,
    input  logic             tx_empty,
    input  logic             lsr_rd,
    input  logic             rbr_rd,
    input  logic             thr_wr,
    input  logic             iir_rd,
    output logic [7:0]       iir_data,
    output logic             irq
);
    logic err_pend, idle_exp, txe_pend, tx_empty_q;
    logic txe_rise, txe_clr;
    iid_e code;
    src_t req;

    // Receive line error: sticky until line status read.
    sirq_sticky #(.RST_VAL(1'b0)) u_err (
        .clk(clk), .rst(rst),
        .set_i(|rx_err), .clr_i(lsr_rd),
        .pend_o(err_pend)
    );

    // Receive idle time-out, FIFO mode only.
    sirq_idle_timer #(.CHARS(TIMEOUT_CHARS)) u_idle (
        .clk(clk), .rst(rst),
        .run_i(fifo_en && rx_nonempty),
        .restart_i(rx_push || rbr_rd),
        .tick_i(char_tick),
        .expired_o(idle_exp)
    );

    // Transmit-empty: armed on rising edge of the empty level.
    always_ff @(posedge clk) begin
        if (rst) tx_empty_q <= 1'b1;
        else     tx_empty_q <= tx_empty;
    end

    assign txe_rise = tx_empty && !tx_empty_q;
    assign txe_clr  = thr_wr || (iir_rd && code == IID_TXEMPTY);

    sirq_sticky #(.RST_VAL(1'b0)) u_txe (
        .clk(clk), .rst(rst),
        .set_i(txe_rise), .clr_i(txe_clr),
        .pend_o(txe_pend)
    );

    always_comb begin
        req.rxerr   = en_rxerr   && err_pend;
        req.rxdata  = en_rxdata  && (fifo_en ? rx_trig : rx_ready);
        req.rxidle  = en_rxdata  && fifo_en && idle_exp;
        req.txempty = en_txempty && txe_pend;
    end

    sirq_prio_enc u_enc (
        .req_i(req), .fifo_on_i(fifo_en),
        .code_o(code), .iir_o(iir_data)
    );

    assign irq = !iir_data[0];
endmodule

// File: rtl/sirq_id_chk.sv
module sirq_id_chk #(
    parameter int TIMEOUT_CHARS = 4,
    parameter int ERR_W         = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             fifo_en,
    input logic             en_rxerr,
    input logic             en_rxdata,
    input logic             en_txempty,
    input logic [ERR_W-1:0] rx_err,
    input logic             rx_ready,
    input logic             rx_trig,
    input logic             rx_nonempty,
    input logic             rx_push,
    input logic             char_tick,
    input logic             tx_empty,
    input logic             lsr_rd,
    input logic             rbr_rd,
    input logic             thr_wr,
    input logic             iir_rd,
    input logic [7:0]       iir_data,
    input logic             irq
);
    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
        irq == !iir_data[0]); // R3

    AST_NO_IDLE_NOFIFO: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |-> !iir_data[3]); // R7

    AST_ERR_RAISE: assert property (@(posedge clk) disable iff (rst)
        (en_rxerr && |rx_err) |=> iir_data[3:0] == 4'b0110); // R4

    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (lsr_rd && rx_err == '0) |=> iir_data[3:0] != 4'b0110); // R4

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        rbr_rd |=> iir_data[3:0] != 4'b1100); // R6

    AST_TXE_WR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (thr_wr && !tx_empty) |=> iir_data[3:0] != 4'b0010); // R8
endmodule

bind sirq_id_unit sirq_id_chk #(.TIMEOUT_CHARS(TIMEOUT_CHARS), .ERR_W(ERR_W)) u_chk (.*);

// File: tb/sirq_id_unit_tb.sv
`timescale 1ns/1ps
module sirq_id_unit_tb;
    localparam int TO = 4;
    localparam int EW = 4;

    logic clk = 0, rst = 1;
    logic fifo_en = 0, en_rxerr = 0, en_rxdata = 0, en_txempty = 0;
    logic [EW-1:0] rx_err = '0;
    logic rx_ready = 0, rx_trig = 0, rx_nonempty = 0, rx_push = 0, char_tick = 0;
    logic tx_empty = 0, lsr_rd = 0, rbr_rd = 0, thr_wr = 0, iir_rd = 0;
    logic [7:0] iir_data;
    logic irq;

    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sirq_id_unit #(.TIMEOUT_CHARS(TO), .ERR_W(EW)) u_dut (
        .clk(clk), .rst(rst), .fifo_en(fifo_en),
        .en_rxerr(en_rxerr), .en_rxdata(en_rxdata), .en_txempty(en_txempty),
        .rx_err(rx_err), .rx_ready(rx_ready), .rx_trig(rx_trig),
        .rx_nonempty(rx_nonempty), .rx_push(rx_push), .char_tick(char_tick),
        .tx_empty(tx_empty), .lsr_rd(lsr_rd), .rbr_rd(rbr_rd),
        .thr_wr(thr_wr), .iir_rd(iir_rd), .iir_data(iir_data), .irq(irq)
    );

    // Behavioural reference model
    bit m_err, m_txe, m_txprev;
    int m_idle;

    function automatic logic [7:0] m_iir();
        logic [3:0] c;
        if (en_rxerr && m_err) c = 4'b0110;
        else if (en_rxdata && (fifo_en ? rx_trig : rx_ready)) c = 4'b0100;
        else if (en_rxdata && fifo_en && m_idle >= TO) c = 4'b1100;
        else if (en_txempty && m_txe) c = 4'b0010;
        else c = 4'b0001;
        return {fifo_en, fifo_en, 2'b00, c};
    endfunction

    always @(posedge clk) begin
        logic [7:0] cur;
        cur = m_iir();
        if (rst) begin
            m_err = 0; m_txe = 0; m_txprev = 1; m_idle = 0;
        end else begin
            if (rx_err != '0) m_err = 1;
            else if (lsr_rd) m_err = 0;
            if (tx_empty && !m_txprev) m_txe = 1;
            else if (thr_wr || (iir_rd && cur[3:0] == 4'b0010)) m_txe = 0;
            m_txprev = tx_empty;
            if (!fifo_en || !rx_nonempty || rx_push || rbr_rd) m_idle = 0;
            else if (char_tick && m_idle < TO) m_idle++;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [7:0] e;
            e = m_iir();
            checks++;
            if (iir_data !== e || irq !== !e[0]) begin
                errors++;
                $display("FAIL MODEL t=%0t iir=%h irq=%b expected iir=%h irq=%b",
                         $time, iir_data, irq, e, !e[0]);
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
        rx_err = '0; rx_push = 0; char_tick = 0;
        lsr_rd = 0; rbr_rd = 0; thr_wr = 0; iir_rd = 0;
        #1;
    endtask

    task automatic chk(string tag, logic [7:0] exp);
        checks++;
        if (iir_data !== exp || irq !== !exp[0]) begin
            errors++;
            $display("FAIL %s iir=%h irq=%b expected iir=%h irq=%b",
                     tag, iir_data, irq, exp, !exp[0]);
        end
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin char_tick = 1; step(); end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 0; step();
        chk("R1 reset", 8'h01);
        fifo_en = 1; step(); chk("R2 fifo bits", 8'hC1);
        fifo_en = 0; step(); chk("R2 fifo off", 8'h01);

        en_rxerr = 1; en_rxdata = 1; en_txempty = 1;
        // R4 each error bit
        for (int b = 0; b < EW; b++) begin
            rx_err[b] = 1; step(); chk("R4 raise", 8'h06);
            step(); chk("R4 hold", 8'h06);
            lsr_rd = 1; step(); chk("R4 clear", 8'h01);
        end
        // R12 set wins
        rx_err = 4'b1000; lsr_rd = 1; step(); chk("R12 err set wins", 8'h06);
        lsr_rd = 1; step(); chk("R3 idle bit0", 8'h01);

        // R5
        rx_ready = 1; step(); chk("R5 ready", 8'h04);
        rx_ready = 0; rx_trig = 1; step(); chk("R5 trig ignored nofifo", 8'h01);
        fifo_en = 1; step(); chk("R5 trig fifo", 8'hC4);
        rx_ready = 1; rx_trig = 0; step(); chk("R5 ready ignored fifo", 8'hC1);
        rx_ready = 0;

        // R6
        rx_nonempty = 1; step();
        ticks(TO - 1); chk("R6 before limit", 8'hC1);
        ticks(1); chk("R6 timeout", 8'hCC);
        rbr_rd = 1; step(); chk("R6 rbr clears", 8'hC1);
        ticks(TO - 1); rx_push = 1; step();
        ticks(TO - 1); chk("R6 push restart", 8'hC1);
        ticks(1); chk("R6 timeout again", 8'hCC);
        rx_nonempty = 0; step(); chk("R6 empty clears", 8'hC1);

        // R7
        fifo_en = 0; rx_nonempty = 1; step();
        ticks(TO + 1); chk("R7 no timeout nofifo", 8'h01);
        rx_nonempty = 0;

        // R8
        tx_empty = 1; step(); chk("R8 rise", 8'h02);
        tx_empty = 0; thr_wr = 1; step(); chk("R8 thr write clears", 8'h01);
        tx_empty = 1; step(); chk("R8 rise again", 8'h02);

        // R9
        iir_rd = 1; step(); chk("R9 read clears", 8'h01);
        tx_empty = 0; step(); tx_empty = 1; step(); chk("R9 rearm", 8'h02);
        rx_err = 4'b0010; step(); chk("R10 err over txe", 8'h06);
        iir_rd = 1; step(); chk("R9 read of other code", 8'h06);
        lsr_rd = 1; step(); chk("R9 txe kept", 8'h02);

        // R10
        rx_ready = 1; step(); chk("R10 data over txe", 8'h04);
        rx_err = 4'b0001; step(); chk("R10 err over data", 8'h06);
        lsr_rd = 1; rx_ready = 0; step();
        fifo_en = 1; rx_nonempty = 1; rx_trig = 1; step();
        ticks(TO); chk("R10 data over timeout", 8'hC4);
        rx_trig = 0; step(); chk("R10 timeout over txe", 8'hCC);
        rbr_rd = 1; step(); chk("R10 txe after timeout", 8'hC2);
        fifo_en = 0; rx_nonempty = 0; step(); chk("R2 bits drop", 8'h02);

        // R11
        en_txempty = 0; step(); chk("R11 txe masked", 8'h01);
        iir_rd = 1; step();
        en_rxerr = 0; rx_err = 4'b0100; step(); chk("R11 err masked", 8'h01);
        en_rxdata = 0; rx_ready = 1; step(); chk("R11 data masked", 8'h01);
        rx_ready = 0; en_rxdata = 1;
        en_txempty = 1; step(); chk("R11 txe revealed", 8'h02);
        en_rxerr = 1; step(); chk("R11 err revealed", 8'h06);
        lsr_rd = 1; step(); chk("R11 after clear", 8'h02);

        // R12 txe set and iir read together
        tx_empty = 0; step(); chk("R12 still pending", 8'h02);
        tx_empty = 1; iir_rd = 1; step(); chk("R12 txe set wins", 8'h02);

        step();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule